// File: doc/BRIEF.md
# Transfer-Request Queue with Occupancy Monitor

This block is a sixteen-slot circular queue for transfer-request entries. A producer pushes entries through a valid/ready port. A consumer takes them from the head through a second valid/ready port. The payload width is a parameter. The queue does not reorder entries; it only stores them in arrival order.

Alongside the storage, the block keeps live status in a read-only 32-bit word. The word holds the slot index of the head entry, the number of entries held now, and the peak occupancy seen since reset or since the last clear. It also holds a sticky flag that rises once occupancy goes above a programmable threshold. A single one-cycle clear strobe rearms the flag and restarts peak tracking from the current occupancy. Software or a supervising block can read the word at any time to judge how close the queue came to overflowing.

Top module: `req_queue_monitor`

## Requirements
- R1: After reset the status word is all zero, `pop_valid` is 0 and `push_ready` is 1.
- R2: Entries leave in the order they were accepted. `pop_data` always presents the oldest stored entry.
- R3: The entry count stays between 0 and 16. `push_ready` is 0 exactly when the count is 16. A push offered while full is not stored and does not disturb the stored entries.
- R4: `pop_valid` is 0 exactly when the count is 0. A pop request while empty changes nothing.
- R5: A push and a pop accepted in the same cycle leave the count unchanged and advance the head by one.
- R6: The head index (status bits 3:0) increases by one for every accepted pop and wraps from 15 to 0.
- R7: The peak field (bits 20:16) equals the largest count reached since reset or the last clear. It does not fall when entries drain.
- R8: The flag (bit 24) becomes 1 on the same clock edge at which the count becomes greater than `thresh`. It then stays 1 until a clear.
- R9: A cycle with `clr_pulse` high clears the flag and loads the peak field with the count as updated in that cycle. If that updated count is greater than `thresh`, the flag is 1 after the edge.
- R10: With `thresh` at 16 or above, the flag never rises, even at a count of 16.
- R11: The status word carries the count in bits 12:8 and reads zero in bits 31:25, 23:21, 15:13 and 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers an entry |
| push_data | input | DATA_W | Entry payload |
| push_ready | output | 1 | Queue can accept an entry |
| pop_valid | output | 1 | Head entry is available |
| pop_data | output | DATA_W | Head entry payload |
| pop_ready | input | 1 | Consumer takes the head entry |
| thresh | input | 5 | Occupancy threshold for the flag |
| clr_pulse | input | 1 | Write-one-to-clear for flag and peak |
| status | output | 32 | Packed status word |

## Verification
The bench fills the queue to 16 and keeps pushing. A design that let `push_ready` stay high there would overwrite the head entry, and the drained data would come out wrong. It pairs pushes with pops while the queue is partly full and while it is empty. Here a wrong count rule would show up either as drift in the count field or as a phantom pop from an empty queue. It drives the head index through the 15-to-0 wrap, which catches a pointer that saturates or is too wide. It also fires the clear strobe both at low occupancy and in the very cycle that pushes occupancy past the threshold. A design that zeroed the peak, or let the clear override a fresh crossing, would then report a wrong peak or a cleared flag. Thresholds of 16 and 31 with a full queue check that the comparison is never satisfiable there.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned FIELD_W  = 5;
  localparam int unsigned PTRF_W   = 4;
  localparam int unsigned FLAG_POS = 24;
  localparam int unsigned PEAK_LSB = 16;
  localparam int unsigned CNT_LSB  = 8;
  localparam int unsigned HEAD_LSB = 0;

  typedef struct packed {
    logic               flag;
    logic [FIELD_W-1:0] peak;
    logic [FIELD_W-1:0] count;
    logic [PTRF_W-1:0]  head;
  } rq_stat_t;
endpackage

// File: rtl/rq_store.sv
module rq_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PTR_W  = $clog2(DEPTH),
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              pop_ready,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  count_nxt,
  output logic [PTR_W-1:0]  head_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic              push_fire, pop_fire;
  logic              head_en, count_en;
  logic [PTR_W-1:0]  head_nxt, tail_w;

  assign push_ready = (count_q != FULL_CNT);
  assign pop_valid  = (count_q != '0);
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop_ready & pop_valid;
  assign tail_w     = PTR_W'(head_q + count_q[PTR_W-1:0]);
  assign pop_data   = slot_q[head_q];

  always_comb begin
    head_en   = pop_fire;
    head_nxt  = PTR_W'(head_q + 1'b1);
    count_en  = push_fire ^ pop_fire;
    count_nxt = count_q;
    if (push_fire && !pop_fire) count_nxt = CNT_W'(count_q + 1'b1);
    else if (pop_fire && !push_fire) count_nxt = CNT_W'(count_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (head_en)  head_q  <= head_nxt;
      if (count_en) count_q <= count_nxt;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic wr_en;
    assign wr_en = push_fire && (tail_w == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q[gi] <= push_data;
    end
  end
endmodule

// File: rtl/rq_peak.sv
module rq_peak #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [THR_W-1:0] thresh,
  input  logic             clr_pulse,
  output logic [CNT_W-1:0] peak_q,
  output logic             flag_q
);
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CNT_W-1:0] peak_nxt;
  logic             flag_nxt, above, peak_en, flag_en;

  always_comb begin
    above    = CMP_W'(count_nxt) > CMP_W'(thresh);
    peak_en  = clr_pulse || (count_nxt > peak_q);
    peak_nxt = count_nxt;
    flag_en  = clr_pulse || above;
    flag_nxt = above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (peak_en) peak_q <= peak_nxt;
      if (flag_en) flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/rq_status.sv
module rq_status
  import rq_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned PTR_W = 4
) (
  input  logic             flag,
  input  logic [CNT_W-1:0] peak,
  input  logic [CNT_W-1:0] count,
  input  logic [PTR_W-1:0] head,
  output logic [STAT_W-1:0] status
);
  rq_stat_t f;

  always_comb begin
    f.flag  = flag;
    f.peak  = FIELD_W'(peak);
    f.count = FIELD_W'(count);
    f.head  = PTRF_W'(head);
    status  = '0;
    status[FLAG_POS]                     = f.flag;
    status[PEAK_LSB +: FIELD_W]          = f.peak;
    status[CNT_LSB +: FIELD_W]           = f.count;
    status[HEAD_LSB +: PTRF_W]           = f.head;
  end
endmodule

// File: rtl/req_queue_monitor.sv
module req_queue_monitor
  import rq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              pop_ready,
  input  logic [4:0]        thresh,
  input  logic              clr_pulse,
  output logic [31:0]       status
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count_q, count_nxt, peak_q;
  logic [PTR_W-1:0] head_q;
  logic             flag_q;

  rq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
    .count_q(count_q), .count_nxt(count_nxt), .head_q(head_q)
  );

  rq_peak #(.CNT_W(CNT_W), .THR_W(5)) u_peak (
    .clk(clk), .rst_n(rst_n), .count_nxt(count_nxt), .thresh(thresh),
    .clr_pulse(clr_pulse), .peak_q(peak_q), .flag_q(flag_q)
  );

  rq_status #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_status (
    .flag(flag_q), .peak(peak_q), .count(count_q), .head(head_q), .status(status)
  );

  logic unused_cnt;
  assign unused_cnt = ^count_q;
endmodule

// File: rtl/rq_chk.sv
module rq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push_valid,
  input logic        push_ready,
  input logic        pop_valid,
  input logic        pop_ready,
  input logic [4:0]  thresh,
  input logic        clr_pulse,
  input logic [31:0] status
);
  logic [4:0] cnt, pk;
  logic [3:0] hd;
  logic       flg;
  assign cnt = status[12:8];
  assign pk  = status[20:16];
  assign hd  = status[3:0];
  assign flg = status[24];

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 5'd16);
  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 5'd16) |-> !push_ready);
  // R4
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 5'd0) |-> !pop_valid);
  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && pop_valid && pop_ready) |=> cnt == $past(cnt));
  // R6
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> hd == 4'($past(hd) + 4'd1));
  // R7
  peak_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) pk >= cnt);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (flg && !clr_pulse) |=> flg);
  // R9
  clr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_pulse |=> pk == cnt);
  // R10
  high_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh >= 5'd16 && !flg) |=> !flg);
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:25] == 7'd0) && (status[23:21] == 3'd0) && (status[15:13] == 3'd0) && (status[7:4] == 4'd0));
endmodule

bind req_queue_monitor rq_chk u_rq_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
  .pop_valid(pop_valid), .pop_ready(pop_ready), .thresh(thresh),
  .clr_pulse(clr_pulse), .status(status)
);

// File: tb/test_req_queue_monitor.sv
`timescale 1ns/1ps
module test_req_queue_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid, pop_ready, clr_pulse;
  logic [31:0] push_data, pop_data, status;
  logic        push_ready, pop_valid;
  logic [4:0]  thresh;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int e_cnt = 0, e_head = 0, e_peak = 0;
  bit e_flag = 1'b0;
  logic [31:0] mdl[$];

  always #2 clk = ~clk;

  req_queue_monitor #(.DATA_W(32), .DEPTH(16)) i_req_queue_monitor (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .pop_ready(pop_ready), .thresh(thresh), .clr_pulse(clr_pulse), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[24]    = e_flag;
    w[20:16] = 5'(e_peak);
    w[12:8]  = 5'(e_cnt);
    w[3:0]   = 4'(e_head);
    return w;
  endfunction

  task automatic chk_status(input string tag);
    chk(status === exp_word(), {tag, " status"}, status, exp_word());
    chk(push_ready === (e_cnt != 16), {tag, " R3 push_ready"}, 32'(push_ready), 32'(e_cnt != 16));
    chk(pop_valid === (e_cnt != 0), {tag, " R4 pop_valid"}, 32'(pop_valid), 32'(e_cnt != 0));
  endtask

  task automatic step(input bit pv, input logic [31:0] pd, input bit pr, input bit cl, input string tag);
    bit fp, fo;
    push_valid = pv; push_data = pd; pop_ready = pr; clr_pulse = cl;
    fp = pv && (e_cnt < 16);
    fo = pr && (e_cnt > 0);
    if (fo) chk(pop_data === mdl[0], {tag, " R2 pop_data"}, pop_data, mdl[0]);
    @(posedge clk); #1;
    push_valid = 0; pop_ready = 0; clr_pulse = 0;
    if (fo) void'(mdl.pop_front());
    if (fp) mdl.push_back(pd);
    e_cnt  = e_cnt + int'(fp) - int'(fo);
    e_head = (e_head + int'(fo)) % 16;
    e_flag = (cl ? 1'b0 : e_flag) | (e_cnt > int'(thresh));
    e_peak = cl ? e_cnt : ((e_cnt > e_peak) ? e_cnt : e_peak);
    chk_status(tag);
  endtask

  task automatic t_reset();
    chk(status === 32'd0, "R1 status after reset", status, 32'd0);
    chk(pop_valid === 1'b0, "R1 pop_valid after reset", 32'(pop_valid), 0);
    chk(push_ready === 1'b1, "R1 push_ready after reset", 32'(push_ready), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) step(1, 32'hA000 + i, 0, 0, "R2 fill");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, "R2 drain");
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) step(1, 32'hB100 + i, 0, 0, "R3 fill");
    for (int i = 0; i < 3; i++) step(1, 32'hDEAD, 0, 0, "R3 push while full");
    chk(status[12:8] === 5'd16, "R11 count field bits 12:8", 32'(status[12:8]), 16);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 0, "R3 drain after full");
  endtask

  task automatic t_empty();
    step(0, 0, 1, 0, "R4 pop while empty");
    step(0, 0, 1, 0, "R4 pop while empty again");
    step(1, 32'hC0DE, 1, 0, "R4 push with pop on empty");
    step(0, 0, 1, 0, "R4 drain single");
  endtask

  task automatic t_pair();
    for (int i = 0; i < 3; i++) step(1, 32'hD000 + i, 0, 0, "R5 prefill");
    for (int i = 0; i < 6; i++) step(1, 32'hD100 + i, 1, 0, "R5 push and pop");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R5 drain");
  endtask

  task automatic t_wrap();
    step(1, 32'hE000, 0, 0, "R6 seed");
    for (int i = 0; i < 20; i++) step(1, 32'hE100 + i, 1, 0, "R6 head wrap");
    step(0, 0, 1, 0, "R6 drain");
  endtask

  task automatic t_peak();
    step(0, 0, 0, 1, "R9 clear at zero");
    for (int i = 0; i < 7; i++) step(1, 32'hF000 + i, 0, 0, "R7 rise");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R7 fall keeps peak");
  endtask

  task automatic t_flag();
    thresh = 5'd4;
    step(0, 0, 0, 1, "R9 clear at count 3");
    step(1, 32'h1111, 0, 0, "R8 count 4 at thresh 4");
    step(1, 32'h2222, 0, 0, "R8 count 5 above thresh");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, "R8 flag sticky on drain");
  endtask

  task automatic t_clear();
    thresh = 5'd2;
    step(1, 32'h3001, 0, 0, "R8 one");
    step(1, 32'h3002, 0, 0, "R8 two");
    step(1, 32'h3003, 0, 0, "R8 three sets flag");
    step(0, 0, 1, 0, "R9 pop to two");
    step(0, 0, 0, 1, "R9 clear reloads peak with 2");
    step(1, 32'h3004, 0, 1, "R9 clear with crossing keeps flag");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R9 drain");
    step(0, 0, 0, 1, "R9 final clear");
  endtask

  task automatic t_high_thr();
    thresh = 5'd16;
    for (int i = 0; i < 17; i++) step(1, 32'h4000 + i, 0, 0, "R10 thresh 16 full");
    thresh = 5'd31;
    step(0, 0, 0, 0, "R10 thresh 31 full");
    step(0, 0, 1, 0, "R10 thresh 31 pop");
    chk(status[24] === 1'b0, "R10 flag stays low", 32'(status[24]), 0);
    for (int i = 0; i < 15; i++) step(0, 0, 1, 0, "R10 drain");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 0; push_valid = 0; push_data = 0; pop_ready = 0; clr_pulse = 0; thresh = 5'd31;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_order();
    t_full();
    t_empty();
    t_pair();
    t_wrap();
    t_peak();
    t_flag();
    t_clear();
    t_high_thr();
    finish_run();
  end
endmodule